// File: doc/BRIEF.md
# Synchronous Byte-Write SRAM Core

This block is a single-port static memory clocked on the rising edge. Each word is 36 bits, organised as four 9-bit lanes. The command inputs are sampled together on every rising edge: a select (active low), a read/write flag (low means write), the address and four per-lane write selects (active low). A selected read puts the addressed word on the output in the cycle that follows the command edge.

A write is a late write. The address and the lane selects are taken at the command edge, and the data word is taken from the data input at the next rising edge. Only the lanes that were selected at the command edge are updated.

The shared bidirectional bus is split into a data input, a data output and an output-drive flag, so that the pad logic can build the tristate buffer. The output is driven only in the cycle after a selected read. The drive is gated at once by an asynchronous output enable (active low) and by an asynchronous sleep input. The output stays off after writes and deselects, and during sleep. Sleep blocks new commands and keeps all stored data.

Top module: `sbw_sram`

## Requirements
- R1: A selected read (sel_n low, wr_n high, sleep low at the edge) makes drive high and dout equal to the stored word at that address in the cycle after the edge, provided oe_n and sleep are low.
- R2: A write command (sel_n low, wr_n low) captures the address and the lane mask at its edge. The data word on din is captured at the next rising edge. Lane i occupies bits [9*i+8:9*i], and it is written only if lane_wr_n[i] was low at the command edge.
- R3: A read at the same edge that commits a pending write to the same address returns the merged new word.
- R4: An edge with sel_n high performs no access, and drive is low in the cycle after it.
- R5: drive is low in the cycle after a write command edge (the write data cycle), whatever oe_n is.
- R6: oe_n high forces drive low at once, without waiting for a clock edge.
- R7: dout is all zeros whenever drive is low.
- R8: While sleep is high, commands are ignored and drive is low. A write accepted before sleep still captures its data. Stored contents are kept, and commands are accepted again from the first edge after sleep falls.
- R9: While reset is active, and right after it, drive is low and no write is pending.
- R10: A write command with all lane selects high leaves the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears control state only |
| sel_n | input | 1 | Select, active low, sampled at the edge |
| wr_n | input | 1 | Low = write, high = read, sampled at the edge |
| lane_wr_n | input | 4 | Per-lane write selects, active low, bit i for lane i |
| addr | input | 6 | Word address |
| din | input | 36 | Write data, taken one edge after the write command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |
| dout | output | 36 | Read data, zero when not driven |
| drive | output | 1 | High when the data bus should be driven |

## Verification
The checker tests the drive gating on every cycle: it is off after writes, deselects and during sleep, it follows oe_n, it turns on after a read, and dout is zero while undriven. Only the bench's scenarios can show that the data is correct. This covers the late-write data capture, the lane masking, the bypass when a read meets a committing write, and the contents after a sleep. The bench compares both outputs each cycle against a behavioural model of the memory.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    // Command seen at a clock edge
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_SLEEP = 2'd3
    } sbw_cmd_e;

endpackage

// File: rtl/sbw_cmd_decode.sv
module sbw_cmd_decode
    import sbw_pkg::*;
(
    input  logic     sel_n,
    input  logic     wr_n,
    input  logic     sleep,
    output sbw_cmd_e cmd
);

    always_comb begin
        if (sleep) begin
            cmd = CMD_SLEEP;
        end else if (sel_n) begin
            cmd = CMD_IDLE;
        end else if (wr_n) begin
            cmd = CMD_READ;
        end else begin
            cmd = CMD_WRITE;
        end
    end

endmodule

// File: rtl/sbw_store.sv
module sbw_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    // One array per lane, so each lane has a single writer
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) begin
                lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/sbw_lane_merge.sv
module sbw_lane_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] old_word,
    input  logic [LANES*LANE_W-1:0] new_word,
    input  logic [LANES-1:0]        lane_en,
    output logic [LANES*LANE_W-1:0] merged
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = lane_en[g] ? new_word[g*LANE_W +: LANE_W]
                                                       : old_word[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/sbw_drive_ctrl.sv
module sbw_drive_ctrl #(
    parameter int WORD_W = 36
) (
    input  logic              rd_valid,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [WORD_W-1:0] word,
    output logic              drive,
    output logic [WORD_W-1:0] dout
);

    // oe_n and sleep act without a clock edge
    always_comb begin
        drive = rd_valid && !oe_n && !sleep;
        dout  = drive ? word : '0;
    end

endmodule

// File: rtl/sbw_sram.sv
module sbw_sram
    import sbw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    oe_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    drive
);

    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic              wr_pend;
        logic [ADDR_W-1:0] wr_addr;
        logic [LANES-1:0]  wr_lanes;
        logic              rd_valid;
        logic [WORD_W-1:0] rd_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    sbw_cmd_e          cmd;
    logic [WORD_W-1:0] store_rd;
    logic [WORD_W-1:0] merged_rd;
    logic              bypass_hit;

    sbw_cmd_decode u_dec (
        .sel_n (sel_n),
        .wr_n  (wr_n),
        .sleep (sleep),
        .cmd   (cmd)
    );

    // The pending write commits din at the edge after its command
    sbw_store #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_store (
        .clk     (clk),
        .we      (ctl_q.wr_pend),
        .wr_addr (ctl_q.wr_addr),
        .lane_en (ctl_q.wr_lanes),
        .wr_data (din),
        .rd_addr (addr),
        .rd_data (store_rd)
    );

    sbw_lane_merge #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_merge (
        .old_word (store_rd),
        .new_word (din),
        .lane_en  (ctl_q.wr_lanes),
        .merged   (merged_rd)
    );

    assign bypass_hit = ctl_q.wr_pend && (ctl_q.wr_addr == addr);

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.wr_pend  = 1'b0;
        ctl_d.rd_valid = 1'b0;
        unique case (cmd)
            CMD_WRITE: begin
                ctl_d.wr_pend  = 1'b1;
                ctl_d.wr_addr  = addr;
                ctl_d.wr_lanes = ~lane_wr_n;
            end
            CMD_READ: begin
                ctl_d.rd_valid = 1'b1;
                ctl_d.rd_data  = bypass_hit ? merged_rd : store_rd;
            end
            default: begin
                // idle or sleep: nothing new is accepted
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sbw_drive_ctrl #(
        .WORD_W (WORD_W)
    ) u_drv (
        .rd_valid (ctl_q.rd_valid),
        .oe_n     (oe_n),
        .sleep    (sleep),
        .word     (ctl_q.rd_data),
        .drive    (drive),
        .dout     (dout)
    );

endmodule

// File: rtl/sbw_sram_chk.sv
module sbw_sram_chk #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sel_n,
    input logic                    wr_n,
    input logic                    oe_n,
    input logic                    sleep,
    input logic [LANES*LANE_W-1:0] dout,
    input logic                    drive
);

    // R6: oe_n high blocks the drive
    p_oe_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive);

    // R8: no drive during sleep
    p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !drive);

    // R4: the cycle after a deselect edge is undriven
    p_desel_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !sleep) |=> !drive);

    // R5: the write data cycle is undriven
    p_wdata_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n && !sleep) |=> !drive);

    // R1: a read is driven in the next cycle when enabled
    p_read_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wr_n && !sleep) ##1 (!oe_n && !sleep) |-> drive);

    // R7: undriven output is zero
    p_zero_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> (dout == '0));

endmodule

bind sbw_sram sbw_sram_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_n (sel_n),
    .wr_n  (wr_n),
    .oe_n  (oe_n),
    .sleep (sleep),
    .dout  (dout),
    .drive (drive)
);

// File: tb/sbw_sram_tb_top.sv
`timescale 1ns/1ps
module sbw_sram_tb_top;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int WW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [NL-1:0] lane_wr_n = '1;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] din = '0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [WW-1:0] dout;
    logic          drive;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    // behavioural model state
    logic [WW-1:0] ref_mem [1<<AW];
    bit            m_pend = 0;
    int            m_waddr = 0;
    logic [NL-1:0] m_lanes = '0;
    bit            m_rvalid = 0;
    logic [WW-1:0] m_rdata = '0;

    always #2 clk = ~clk;

    sbw_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .wr_n      (wr_n),
        .lane_wr_n (lane_wr_n),
        .addr      (addr),
        .din       (din),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .dout      (dout),
        .drive     (drive)
    );

    task automatic compare(input string tag);
        bit            e_drv;
        logic [WW-1:0] e_out;
        e_drv = m_rvalid && !oe_n && !sleep;
        e_out = e_drv ? m_rdata : '0;
        vectors++;
        if (drive !== e_drv) begin
            errors++;
            $display("FAIL %s drive: got %b expected %b", tag, drive, e_drv);
        end
        vectors++;
        if (dout !== e_out) begin
            errors++;
            $display("FAIL %s dout: got %h expected %h", tag, dout, e_out);
        end
    endtask

    // drive one cycle's inputs, check, advance the model, take the edge
    task automatic step(input string tag, input bit s_n, input bit w_n,
                        input logic [NL-1:0] ln, input int a,
                        input logic [WW-1:0] d, input bit oe, input bit slp);
        @(negedge clk);
        sel_n = s_n; wr_n = w_n; lane_wr_n = ln; addr = a[AW-1:0];
        din = d; oe_n = oe; sleep = slp;
        #1;
        compare(tag);
        if (m_pend) begin
            for (int i = 0; i < NL; i++)
                if (m_lanes[i]) ref_mem[m_waddr][i*LW +: LW] = d[i*LW +: LW];
        end
        m_pend   = !slp && !s_n && !w_n;
        m_rvalid = !slp && !s_n && w_n;
        if (m_pend) begin
            m_waddr = a;
            m_lanes = ~ln;
        end
        if (m_rvalid) m_rdata = ref_mem[a];
        @(posedge clk);
    endtask

    function automatic logic [WW-1:0] pat(input int k);
        return {4{k[8:0] ^ 9'h15A}} ^ (WW'(k) << 11);
    endfunction

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000 && !done) begin
                errors++;
                $display("FAIL watchdog: got %0d cycles expected completion", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin : stim
        // R9: reset state
        #1;
        compare("R9 reset");
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step("R9 idle after reset", 1, 1, '1, 0, '0, 0, 0);

        // R2: back-to-back late writes of full words
        for (int k = 0; k < 8; k++)
            step("R2 write", 0, 0, '0, k, (k == 0) ? '0 : pat(k-1), 0, 0);
        step("R5 write data cycle", 1, 1, '1, 0, pat(7), 0, 0);

        // R1: read back with consecutive reads
        for (int k = 0; k < 8; k++)
            step("R1 read", 0, 1, '1, k, '0, 0, 0);
        step("R1 last read", 1, 1, '1, 0, '0, 0, 0);

        // R2: partial write, lanes 0 and 2 only
        step("R2 lane write cmd", 0, 0, 4'b1010, 2, '0, 0, 0);
        step("R5 lane data", 1, 1, '1, 0, {WW{1'b1}}, 0, 0);
        step("R2 lane read", 0, 1, '1, 2, '0, 0, 0);
        step("R2 lane result", 1, 1, '1, 0, '0, 0, 0);

        // R10: no lanes selected
        step("R10 null write", 0, 0, 4'b1111, 3, '0, 0, 0);
        step("R10 null data", 1, 1, '1, 0, {WW{1'b1}}, 0, 0);
        step("R10 read", 0, 1, '1, 3, '0, 0, 0);
        step("R10 result", 1, 1, '1, 0, '0, 0, 0);

        // R3: read hits the write being committed
        step("R3 write cmd", 0, 0, 4'b0110, 5, '0, 0, 0);
        step("R3 bypass read", 0, 1, '1, 5, 36'h0_ABCD_1234, 0, 0);
        step("R3 bypass result", 1, 1, '1, 0, '0, 0, 0);

        // R6 and R7: oe_n high during a read result, then low again
        step("R6 read", 0, 1, '1, 1, '0, 0, 0);
        step("R6 oe high", 1, 1, '1, 0, '0, 1, 0);
        step("R6 read again", 0, 1, '1, 1, '0, 1, 0);
        @(negedge clk);
        oe_n = 1'b1; #1; compare("R7 zero while undriven");
        oe_n = 1'b0; #1; compare("R6 async reenable");
        @(posedge clk);

        // R4: deselect between reads
        step("R4 deselect", 1, 0, '0, 4, '0, 0, 0);
        step("R4 off after deselect", 0, 1, '1, 4, '0, 0, 0);
        step("R4 read after deselect", 1, 1, '1, 0, '0, 0, 0);

        // R8: sleep ignores commands, a pending write still lands
        step("R8 write before sleep", 0, 0, '0, 6, '0, 0, 0);
        step("R8 data during sleep", 0, 0, '0, 7, 36'h1_2345_6789, 0, 1);
        step("R8 read ignored", 0, 1, '1, 6, 36'hF_FFFF_FFFF, 0, 1);
        step("R8 release", 0, 1, '1, 6, '0, 0, 0);
        step("R8 read 7", 0, 1, '1, 7, '0, 0, 0);
        step("R8 result 7", 1, 1, '1, 0, '0, 0, 0);
        for (int k = 0; k < 8; k++)
            step("R8 contents kept", 0, 1, '1, k, '0, 0, 0);
        step("R8 final", 1, 1, '1, 0, '0, 0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule